// File: doc/BRIEF.md
# Banked Data Pointer Register File

This block holds a bank of eight 16-bit data pointers that the processor sees through one low-byte and one high-byte special-function-register address. A small select register picks which pointer those two addresses reach. The same selection drives a 16-bit active-pointer output, which the program-memory and external-data-memory paths use as the indirect address. This includes accesses to any extended on-chip RAM region.

Software can keep up to eight live addresses (source, destination, table bases) and switch between them by writing the select register once, instead of saving and restoring one pointer. An increment strobe from the access sequencer advances the active pointer after an indirect access. The strobe carries through the whole 16 bits.

Top module: `banked_dptr_file`

## Requirements
- R1: After reset every pointer holds 0000h, the select value is 0, `act_ptr` is 0000h, and reads of the select, low and high addresses return 00h.
- R2: The select register sits at address 92h. Bits [2:0] of a write choose the pointer, bits [7:3] of the write are ignored, and a read returns the select value in bits [2:0] with bits [7:3] as 0.
- R3: Address 82h reads and writes bits [7:0] of the selected pointer. Address 83h reads and writes bits [15:8] of the selected pointer.
- R4: A write to 82h or 83h changes only the selected pointer. The other seven pointers keep their values.
- R5: A new select value governs reads, writes and `act_ptr` from the cycle after the write. Switching away from a pointer and back loses none of its contents.
- R6: `act_ptr` always presents all 16 bits of the selected pointer.
- R7: A cycle with `ptr_inc` high adds 1 to the selected pointer. The carry passes from bit 7 into bit 8, and FFFFh wraps to 0000h.
- R8: When `ptr_inc` and a write to 82h or 83h fall in the same cycle, the write lands and the increment is dropped.
- R9: A write to any other address changes no pointer and not the select value. A read of any other address returns 00h.
- R10: When `ptr_inc` and a select write fall in the same cycle, the pointer selected before the write is incremented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sfr_addr | input | 8 | Register bus address |
| sfr_we | input | 1 | Register bus write enable |
| sfr_wdata | input | 8 | Register bus write data |
| sfr_rdata | output | 8 | Register bus read data, combinational from `sfr_addr` |
| ptr_inc | input | 1 | Increment strobe for the selected pointer |
| act_ptr | output | 16 | Selected pointer, used as the indirect address |

## Verification
A pointer whose enable decode is wrong is corrupted without any sign at the time of the write. The damage shows only once the bench selects that pointer again, so the bench fills all eight pointers with distinct values and then reads each one back. A fault in the select register or in the increment path shows on `act_ptr` in the very next cycle. The bench checks `act_ptr` after every step, which makes those faults visible one clock after their cause. The carry and wrap cases are driven at the exact byte boundaries.

// File: rtl/dpb_pkg.sv
package dpb_pkg;

   // Which register of the block an address selects
   typedef enum logic [1:0] {
      HIT_NONE = 2'd0,
      HIT_SEL  = 2'd1,
      HIT_LO   = 2'd2,
      HIT_HI   = 2'd3
   } dpb_hit_e;

endpackage

// File: rtl/dpb_decode.sv
module dpb_decode
   import dpb_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter logic [ADDR_W-1:0] SEL_ADDR = 'h92,
   parameter logic [ADDR_W-1:0] LO_ADDR  = 'h82,
   parameter logic [ADDR_W-1:0] HI_ADDR  = 'h83
) (
   input  logic [ADDR_W-1:0] addr,
   output dpb_hit_e          hit
);

   if (SEL_ADDR == LO_ADDR || SEL_ADDR == HI_ADDR || LO_ADDR == HI_ADDR) begin : g_addr_clash
      $error("dpb_decode: register addresses must be distinct");
   end

   always_comb begin
      if (addr == SEL_ADDR)     hit = HIT_SEL;
      else if (addr == LO_ADDR) hit = HIT_LO;
      else if (addr == HI_ADDR) hit = HIT_HI;
      else                      hit = HIT_NONE;
   end

endmodule

// File: rtl/dpb_select.sv
module dpb_select #(
   parameter int DATA_W = 8,
   parameter int SEL_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [SEL_W-1:0]  sel
);

   if (SEL_W < 1 || SEL_W > DATA_W) begin : g_bad_sel_w
      $error("dpb_select: SEL_W must be between 1 and DATA_W");
   end

   logic [SEL_W-1:0] sel_q;

   always_ff @(posedge clk) begin
      if (!rst_n)  sel_q <= '0;
      else if (wr) sel_q <= wdata[SEL_W-1:0];
   end

   assign sel = sel_q;

   AST_SEL_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> sel == $past(wdata[SEL_W-1:0]));  // R2
   AST_SEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(sel));  // R9

endmodule

// File: rtl/dpb_pointer.sv
module dpb_pointer #(
   parameter int DATA_W = 8,
   parameter int PTR_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic              inc,
   input  logic [DATA_W-1:0] wdata,
   output logic [PTR_W-1:0]  value
);

   localparam int HI_LSB = DATA_W;

   if (PTR_W != 2 * DATA_W) begin : g_bad_ptr_w
      $error("dpb_pointer: PTR_W must be twice DATA_W");
   end

   logic [PTR_W-1:0] val_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         val_q <= '0;
      end else if (wr_lo || wr_hi) begin
         if (wr_lo) val_q[HI_LSB-1:0]     <= wdata;
         if (wr_hi) val_q[PTR_W-1:HI_LSB] <= wdata;
      end else if (inc) begin
         val_q <= val_q + 1'b1;
      end
   end

   assign value = val_q;

   AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !wr_lo && !wr_hi) |=> value == $past(value) + 1'b1);  // R7
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !wr_lo && !wr_hi) |=> $stable(value));  // R4
   AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo && !wr_hi) |=> (value[HI_LSB-1:0] == $past(wdata))
                            && (value[PTR_W-1:HI_LSB] == $past(value[PTR_W-1:HI_LSB])));  // R8

endmodule

// File: rtl/banked_dptr_file.sv
module banked_dptr_file
   import dpb_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 8,
   parameter int PTR_COUNT = 8,
   parameter logic [ADDR_W-1:0] SEL_ADDR = 'h92,
   parameter logic [ADDR_W-1:0] LO_ADDR  = 'h82,
   parameter logic [ADDR_W-1:0] HI_ADDR  = 'h83
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   sfr_addr,
   input  logic                sfr_we,
   input  logic [DATA_W-1:0]   sfr_wdata,
   output logic [DATA_W-1:0]   sfr_rdata,
   input  logic                ptr_inc,
   output logic [2*DATA_W-1:0] act_ptr
);

   localparam int PTR_W = 2 * DATA_W;
   localparam int SEL_W = (PTR_COUNT > 1) ? $clog2(PTR_COUNT) : 1;

   if (PTR_COUNT < 2 || (1 << SEL_W) != PTR_COUNT) begin : g_bad_count
      $error("banked_dptr_file: PTR_COUNT must be a power of two, at least 2");
   end
   if (SEL_W > DATA_W) begin : g_bad_sel
      $error("banked_dptr_file: select field wider than the data bus");
   end

   dpb_hit_e         hit;
   logic [SEL_W-1:0] sel;
   logic             sel_wr;
   logic             lo_wr;
   logic             hi_wr;
   logic [PTR_W-1:0] ptr_val [PTR_COUNT];
   logic [PTR_COUNT-1:0] lo_en;
   logic [PTR_COUNT-1:0] hi_en;
   logic [PTR_COUNT-1:0] inc_en;

   dpb_decode #(
      .ADDR_W   (ADDR_W),
      .SEL_ADDR (SEL_ADDR),
      .LO_ADDR  (LO_ADDR),
      .HI_ADDR  (HI_ADDR)
   ) i_decode (
      .addr (sfr_addr),
      .hit  (hit)
   );

   assign sel_wr = sfr_we && (hit == HIT_SEL);
   assign lo_wr  = sfr_we && (hit == HIT_LO);
   assign hi_wr  = sfr_we && (hit == HIT_HI);

   dpb_select #(
      .DATA_W (DATA_W),
      .SEL_W  (SEL_W)
   ) i_select (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (sel_wr),
      .wdata (sfr_wdata),
      .sel   (sel)
   );

   for (genvar g = 0; g < PTR_COUNT; g++) begin : g_ptr
      assign lo_en[g]  = lo_wr   && (sel == SEL_W'(g));
      assign hi_en[g]  = hi_wr   && (sel == SEL_W'(g));
      assign inc_en[g] = ptr_inc && (sel == SEL_W'(g));

      dpb_pointer #(
         .DATA_W (DATA_W),
         .PTR_W  (PTR_W)
      ) i_ptr (
         .clk   (clk),
         .rst_n (rst_n),
         .wr_lo (lo_en[g]),
         .wr_hi (hi_en[g]),
         .inc   (inc_en[g]),
         .wdata (sfr_wdata),
         .value (ptr_val[g])
      );
   end

   assign act_ptr = ptr_val[sel];

   always_comb begin
      case (hit)
         HIT_SEL: sfr_rdata = {{(DATA_W-SEL_W){1'b0}}, sel};
         HIT_LO:  sfr_rdata = act_ptr[DATA_W-1:0];
         HIT_HI:  sfr_rdata = act_ptr[PTR_W-1:DATA_W];
         default: sfr_rdata = '0;
      endcase
   end

   AST_ONE_LO_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lo_en) && $onehot0(hi_en));  // R4
   AST_LO_READ_PATH: assert property (@(posedge clk) disable iff (!rst_n)
      (hit == HIT_LO) |-> sfr_rdata == act_ptr[DATA_W-1:0]);  // R3
   AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (hit == HIT_SEL) |-> sfr_rdata[DATA_W-1:SEL_W] == '0);  // R2
   AST_SELECT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      sel_wr |=> sel == $past(sfr_wdata[SEL_W-1:0]));  // R5
   AST_OTHER_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (hit == HIT_NONE) |-> sfr_rdata == '0);  // R9

endmodule

// File: tb/test_banked_dptr_file.sv
module test_banked_dptr_file;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] sfr_addr = 8'h00;
   logic       sfr_we = 1'b0;
   logic [7:0] sfr_wdata = 8'h00;
   logic [7:0] sfr_rdata;
   logic       ptr_inc = 1'b0;
   logic [15:0] act_ptr;

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   banked_dptr_file i_banked_dptr_file (
      .clk       (clk),
      .rst_n     (rst_n),
      .sfr_addr  (sfr_addr),
      .sfr_we    (sfr_we),
      .sfr_wdata (sfr_wdata),
      .sfr_rdata (sfr_rdata),
      .ptr_inc   (ptr_inc),
      .act_ptr   (act_ptr)
   );

   // Row: {req[3:0], we, inc, addr[7:0], wdata[7:0], rd_addr[7:0], exp_rd[7:0], exp_act[15:0]}
   localparam int NVEC = 17;
   localparam logic [53:0] VEC [NVEC] = '{
      {4'd3,  1'b1, 1'b0, 8'h82, 8'h34, 8'h82, 8'h34, 16'h0034},  // R3 low write
      {4'd3,  1'b1, 1'b0, 8'h83, 8'h12, 8'h83, 8'h12, 16'h1234},  // R3 high write
      {4'd5,  1'b1, 1'b0, 8'h92, 8'h01, 8'h92, 8'h01, 16'h0000},  // R5 switch to 1
      {4'd6,  1'b1, 1'b0, 8'h82, 8'hFF, 8'h82, 8'hFF, 16'h00FF},  // R6
      {4'd7,  1'b0, 1'b1, 8'h00, 8'h00, 8'h83, 8'h01, 16'h0100},  // R7 carry
      {4'd3,  1'b1, 1'b0, 8'h83, 8'hFF, 8'h83, 8'hFF, 16'hFF00},  // R3
      {4'd3,  1'b1, 1'b0, 8'h82, 8'hFF, 8'h82, 8'hFF, 16'hFFFF},  // R3
      {4'd7,  1'b0, 1'b1, 8'h00, 8'h00, 8'h82, 8'h00, 16'h0000},  // R7 wrap
      {4'd2,  1'b1, 1'b0, 8'h92, 8'hF8, 8'h92, 8'h00, 16'h1234},  // R2 reserved bits
      {4'd2,  1'b1, 1'b0, 8'h92, 8'h07, 8'h92, 8'h07, 16'h0000},  // R2 top pointer
      {4'd3,  1'b1, 1'b0, 8'h83, 8'hAB, 8'h83, 8'hAB, 16'hAB00},  // R3
      {4'd9,  1'b1, 1'b0, 8'h50, 8'h77, 8'h50, 8'h00, 16'hAB00},  // R9 other address
      {4'd4,  1'b1, 1'b0, 8'h92, 8'h00, 8'h82, 8'h34, 16'h1234},  // R4 ptr0 kept
      {4'd8,  1'b1, 1'b1, 8'h82, 8'h99, 8'h82, 8'h99, 16'h1299},  // R8 write wins
      {4'd10, 1'b1, 1'b1, 8'h92, 8'h01, 8'h92, 8'h01, 16'h0000},  // R10 old pointer bumped
      {4'd10, 1'b1, 1'b0, 8'h92, 8'h00, 8'h82, 8'h9A, 16'h129A},  // R10 result
      {4'd5,  1'b1, 1'b0, 8'h92, 8'h07, 8'h83, 8'hAB, 16'hAB00}   // R5 ptr7 kept
   };

   task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic step(input logic we, input logic inc, input logic [7:0] a, input logic [7:0] d,
                       input logic [7:0] rd);
      @(negedge clk);
      sfr_we = we; ptr_inc = inc; sfr_addr = a; sfr_wdata = d;
      @(negedge clk);
      sfr_we = 1'b0; ptr_inc = 1'b0; sfr_addr = rd;
      #1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      sfr_addr = 8'h82; #1;
      check("R1 low after reset", {8'h00, sfr_rdata}, 16'h0000);
      sfr_addr = 8'h83; #1;
      check("R1 high after reset", {8'h00, sfr_rdata}, 16'h0000);
      sfr_addr = 8'h92; #1;
      check("R1 select after reset", {8'h00, sfr_rdata}, 16'h0000);
      check("R1 act_ptr after reset", act_ptr, 16'h0000);

      for (int i = 0; i < NVEC; i++) begin
         step(VEC[i][49], VEC[i][48], VEC[i][47:40], VEC[i][39:32], VEC[i][31:24]);
         check($sformatf("R%0d row %0d rdata", VEC[i][53:50], i), {8'h00, sfr_rdata},
               {8'h00, VEC[i][23:16]});
         check($sformatf("R%0d row %0d act_ptr", VEC[i][53:50], i), act_ptr, VEC[i][15:0]);
      end

      // R4: fill all eight pointers with distinct values, then read each back
      for (int k = 0; k < 8; k++) begin
         step(1'b1, 1'b0, 8'h92, 8'(k), 8'h92);
         step(1'b1, 1'b0, 8'h82, 8'(8'h10 + k), 8'h82);
         step(1'b1, 1'b0, 8'h83, 8'(8'hC0 + k), 8'h83);
      end
      for (int k = 0; k < 8; k++) begin
         step(1'b1, 1'b0, 8'h92, 8'(k), 8'h82);
         check("R4 pointer retained", act_ptr, {8'(8'hC0 + k), 8'(8'h10 + k)});
      end

      // R1: reset in mid-run clears every pointer and the select value
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      sfr_addr = 8'h92; #1;
      check("R1 select cleared", {8'h00, sfr_rdata}, 16'h0000);
      for (int k = 0; k < 8; k++) begin
         step(1'b1, 1'b0, 8'h92, 8'(k), 8'h83);
         check("R1 pointer cleared", act_ptr, 16'h0000);
      end

      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule